// File: doc/BRIEF.md
# Line Range and Brown-Out Qualifier

This block turns four comparator decisions on the rectified-line sense voltage into two steady flags: a high-line range flag and a brown-out flag. Each flag has a pair of thresholds. The flag's own state picks which comparator of the pair is listened to. Each flag moves in one direction on the first clock that sees the crossing. It moves back only after the line has stayed on the other side for longer than a qualification window, nominally 25 ms, expressed as `QualCycles` clock cycles.

The high-line flag also drives three mode outputs used elsewhere in a quasi-resonant controller:
- the valley on which the next switching cycle starts,
- the choice of the longer restart watchdog,
- a halving of the current-loop gain.

At reset the line is treated as low and absent until a comparator says otherwise. The comparator inputs are expected to be synchronous to `clk`.

Top module: `line_range_qual`

## Requirements
- R1: After reset `highLine` is 0, `brownOut` is 1 and `valleyNum` is 1.
- R2: While `highLine` is 0, a clock edge that samples `aboveHi`=1 sets `highLine` on that edge.
- R3: While `highLine` is 1, it clears only on the edge that samples `aboveLo`=0 for the (QualCycles+1)-th consecutive time. After QualCycles such edges it is still 1.
- R4: While `highLine` is 1, an edge that samples `aboveLo`=1 restarts the high-line qualification from zero.
- R5: While `highLine` is 0, `aboveLo` has no effect on it. While `highLine` is 1, `aboveHi` has no effect on it.
- R6: While `brownOut` is 1, an edge that samples `aboveBoOn`=1 clears it on that edge. `aboveBoOff` alone never clears it.
- R7: While `brownOut` is 0, it sets only on the edge that samples `aboveBoOff`=0 for the (QualCycles+1)-th consecutive time. An edge with `aboveBoOff`=1 restarts that count. `aboveBoOn` has no effect in this state.
- R8: `valleyNum` is 2 (binary 10) when `highLine` is 1 and 1 (binary 01) otherwise. `wdgLong` and `gainHalf` equal `highLine`.
- R9: The two qualifications run independently. A single line drop or a single line rise can switch both flags on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveHi | input | 1 | Line sense above the high-line entry threshold |
| aboveLo | input | 1 | Line sense above the high-line exit threshold |
| aboveBoOn | input | 1 | Line sense above the brown-out release level |
| aboveBoOff | input | 1 | Line sense above the brown-out entry level |
| highLine | output | 1 | High-line range flag |
| brownOut | output | 1 | Line too low; switching must stop |
| valleyNum | output | 2 | Valley on which to turn on: 1 or 2 |
| wdgLong | output | 1 | Select the longer restart watchdog |
| gainHalf | output | 1 | Halve the current-control gain |

## Verification
Two functions can switch in the same cycle:
- the high-line exit qualification and the brown-out entry qualification;
- on a fast rise, the immediate high-line set and the immediate brown-out release.

The bench provokes the first case by releasing every comparator on one edge and holding them low. Both flags must stay put for exactly QualCycles edges and then flip together on the next one. The second case is provoked by raising all four comparators at once from the brown-out state, and both flags must change on that single edge. In each case the scoreboard holds an expected pair per edge, so a flag that changes one cycle early or late is reported.

// File: rtl/line_qual_pkg.sv
package line_qual_pkg;
  localparam int NumChan = 2;
  localparam int ChanHl  = 0;
  localparam int ChanBo  = 1;

  typedef struct packed {
    logic hlClr;
    logic hlInc;
    logic boClr;
    logic boInc;
  } qualStrobe_t;
endpackage

// File: rtl/line_qual_dp.sv
module line_qual_dp
  import line_qual_pkg::*;
#(
  parameter int QualCycles = 25000
) (
  input  logic         clk,
  input  logic         rstN,
  input  qualStrobe_t  stb,
  output logic         hlExp,
  output logic         boExp
);
  localparam int CntW = $clog2(QualCycles + 1);
  localparam logic [CntW-1:0] CntLimit = CntW'(QualCycles);

  logic [NumChan-1:0] clrVec;
  logic [NumChan-1:0] incVec;
  logic [NumChan-1:0] expVec;

  assign clrVec[ChanHl] = stb.hlClr;
  assign incVec[ChanHl] = stb.hlInc;
  assign clrVec[ChanBo] = stb.boClr;
  assign incVec[ChanBo] = stb.boInc;

  for (genvar g = 0; g < NumChan; g++) begin : g_chan
    logic [CntW-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cnt <= '0;
      else if (clrVec[g]) cnt <= '0;
      else if (incVec[g]) cnt <= cnt + 1'b1;
    end

    assign expVec[g] = (cnt == CntLimit);

    // R4, R7: the window counter never runs past its limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CntLimit);
  end

  assign hlExp = expVec[ChanHl];
  assign boExp = expVec[ChanBo];
endmodule

// File: rtl/line_qual_ctrl.sv
module line_qual_ctrl
  import line_qual_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aboveHi,
  input  logic        aboveLo,
  input  logic        aboveBoOn,
  input  logic        aboveBoOff,
  input  logic        hlExp,
  input  logic        boExp,
  output qualStrobe_t stb,
  output logic        hlQ,
  output logic        boQ
);
  logic hlBelow;
  logic boBelow;
  logic hlNext;
  logic boNext;

  // Active comparator chosen by the flag's own state
  assign hlBelow = hlQ && !aboveLo;
  assign boBelow = !boQ && !aboveBoOff;

  always_comb begin
    stb.hlInc = hlBelow && !hlExp;
    stb.hlClr = !hlBelow || hlExp;
    stb.boInc = boBelow && !boExp;
    stb.boClr = !boBelow || boExp;
  end

  always_comb begin
    if (!hlQ) hlNext = aboveHi;
    else      hlNext = !(hlBelow && hlExp);
    if (boQ)  boNext = !aboveBoOn;
    else      boNext = boBelow && boExp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hlQ <= 1'b0;
      boQ <= 1'b1;
    end else begin
      hlQ <= hlNext;
      boQ <= boNext;
    end
  end

  // R2: entry into high line is immediate
  a_r2_hl_set: assert property (@(posedge clk) disable iff (!rstN)
    (!hlQ && aboveHi) |=> hlQ);
  // R3: no exit from high line before the window expires
  a_r3_hl_qualified: assert property (@(posedge clk) disable iff (!rstN)
    (hlQ && !hlExp) |=> hlQ);
  // R4: exit comparator high keeps the flag
  a_r4_hl_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hlQ && aboveLo) |=> hlQ);
  // R6: release from brown-out is immediate
  a_r6_bo_release: assert property (@(posedge clk) disable iff (!rstN)
    (boQ && aboveBoOn) |=> !boQ);
  // R7: no brown-out entry before the window expires
  a_r7_bo_qualified: assert property (@(posedge clk) disable iff (!rstN)
    (!boQ && !boExp) |=> !boQ);
endmodule

// File: rtl/line_range_qual.sv
module line_range_qual
  import line_qual_pkg::*;
#(
  parameter int QualCycles = 25000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveHi,
  input  logic       aboveLo,
  input  logic       aboveBoOn,
  input  logic       aboveBoOff,
  output logic       highLine,
  output logic       brownOut,
  output logic [1:0] valleyNum,
  output logic       wdgLong,
  output logic       gainHalf
);
  qualStrobe_t stb;
  logic hlExp;
  logic boExp;
  logic hlQ;
  logic boQ;

  line_qual_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .aboveHi    (aboveHi),
    .aboveLo    (aboveLo),
    .aboveBoOn  (aboveBoOn),
    .aboveBoOff (aboveBoOff),
    .hlExp      (hlExp),
    .boExp      (boExp),
    .stb        (stb),
    .hlQ        (hlQ),
    .boQ        (boQ)
  );

  line_qual_dp #(.QualCycles(QualCycles)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .hlExp (hlExp),
    .boExp (boExp)
  );

  assign highLine  = hlQ;
  assign brownOut  = boQ;
  assign valleyNum = hlQ ? 2'd2 : 2'd1;
  assign wdgLong   = hlQ;
  assign gainHalf  = hlQ;

  // R8: the valley number is always a legal valley
  a_r8_valley_legal: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(valleyNum));
endmodule

// File: tb/line_range_qual_tb.sv
`timescale 1ns/1ps
module line_range_qual_tb;
  localparam int Q = 6;

  typedef struct {
    logic  hl;
    logic  bo;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveHi = 1'b0, aboveLo = 1'b0, aboveBoOn = 1'b0, aboveBoOff = 1'b0;
  logic highLine, brownOut, wdgLong, gainHalf;
  logic [1:0] valleyNum;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  expItem_t sbQ[$];

  always #2.5 clk = ~clk;

  line_range_qual #(.QualCycles(Q)) u_dut (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .aboveLo(aboveLo),
    .aboveBoOn(aboveBoOn), .aboveBoOff(aboveBoOff), .highLine(highLine),
    .brownOut(brownOut), .valleyNum(valleyNum), .wdgLong(wdgLong),
    .gainHalf(gainHalf)
  );

  // Driver: apply one edge of stimulus, queue the expected flags after it
  task automatic step(input logic hi, input logic lo, input logic bon,
                      input logic boff, input logic eHl, input logic eBo,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    aboveHi = hi; aboveLo = lo; aboveBoOn = bon; aboveBoOff = boff;
    @(posedge clk);
    #1;
    it.hl = eHl; it.bo = eBo; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compare on the falling edge after each queued edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t it;
      logic [1:0] eV;
      it = sbQ.pop_front();
      eV = it.hl ? 2'd2 : 2'd1;
      total++;
      if (highLine !== it.hl) begin
        bad++;
        $display("FAIL %s highLine act=%b exp=%b", it.tag, highLine, it.hl);
      end
      total++;
      if (brownOut !== it.bo) begin
        bad++;
        $display("FAIL %s brownOut act=%b exp=%b", it.tag, brownOut, it.bo);
      end
      total++;
      if (valleyNum !== eV || wdgLong !== it.hl || gainHalf !== it.hl) begin
        bad++;
        $display("FAIL R8 modes act=%0d/%b/%b exp=%0d/%b/%b",
                 valleyNum, wdgLong, gainHalf, eV, it.hl, it.hl);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    step(0, 0, 0, 0, 0, 1, "R1");
    // R5 exit comparator alone cannot set high line
    step(0, 1, 0, 0, 0, 1, "R5");
    step(0, 1, 0, 0, 0, 1, "R5");
    // R6 brown-out entry comparator alone does not release
    step(0, 1, 0, 1, 0, 1, "R6");
    step(0, 1, 1, 1, 0, 0, "R6");
    // R2 immediate high-line entry
    step(1, 1, 1, 1, 1, 0, "R2");
    // R5 entry comparator dropping is ignored while set
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 0, "R5");
    // R3 exit needs Q+1 consecutive low edges
    for (int i = 0; i < Q; i++) step(0, 0, 1, 1, 1, 0, "R3");
    step(0, 0, 1, 1, 0, 0, "R3");
    step(1, 1, 1, 1, 1, 0, "R2");
    // R4 restart of the window
    for (int i = 0; i < Q; i++) step(0, 0, 1, 1, 1, 0, "R4");
    step(0, 1, 1, 1, 1, 0, "R4");
    for (int i = 0; i < Q; i++) step(0, 0, 1, 1, 1, 0, "R4");
    step(0, 0, 1, 1, 0, 0, "R4");
    step(1, 1, 1, 1, 1, 0, "R2");
    // R9 one drop: both windows expire on the same edge
    for (int i = 0; i < Q; i++) step(0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");
    // R9 one rise: both flags switch on the same edge
    step(1, 1, 1, 1, 1, 1'b0, "R9");
    // drop out of high line, stay powered
    for (int i = 0; i < Q; i++) step(0, 0, 1, 1, 1, 0, "R3");
    step(0, 0, 1, 1, 0, 0, "R3");
    // R7 brown-out entry with restart; release comparator ignored
    for (int i = 0; i < Q; i++) step(0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, "R7");
    for (int i = 0; i < Q; i++) step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, "R7");
    // R6 hysteresis: entry comparator high does not release
    step(0, 0, 0, 1, 0, 1, "R6");
    step(0, 0, 1, 1, 0, 0, "R6");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule